// File: doc/BRIEF.md
# Synchronous serial port master

This block is a memory-mapped SPI master. Software reaches it through a small word-addressed register bus. It queues frames of 4 to 16 bits into an 8-entry transmit FIFO. The block shifts each frame out MSB first on `mosi` while it shifts the reply in from `miso`, and it stores every completed reply in an 8-entry receive FIFO. Chip selects are not part of the block. Software drives them as separate general-purpose lines around each transfer.

The serial clock runs at the core clock divided by an even prescaler and by (1 + SCR). Clock polarity and clock phase can be programmed. A receive overrun occurs when a frame completes while the receive FIFO is full. The block discards that frame and latches a sticky flag. A loopback mode connects `mosi` internally to the receiver. Receive, transmit and overrun conditions are masked and then combined onto a single interrupt line.

Top module: `ssp_master`

## Requirements
- R1: After reset, status reads 0x0003, the prescaler reads 2, control 0, control 1 and interrupt status read 0, and `sclk` and `irq` are low.
- R2: Control 0 (word 0x00) reads back all 16 bits. Control 1 (word 0x04) reads back bits 6:0 only. The prescaler (word 0x10) reads back with bit 0 forced to zero, and any value below 2 reads as 2.
- R3: Control 0 bits 3:0 hold the frame size minus one, for values 3 to 15. A data write (word 0x08) is masked to the frame size. Frames go out MSB first, and a received frame is right-justified with zeros above it.
- R4: Control 0 bit 7 sets the idle level of `sclk`. When control 0 bit 6 is 0, each bit is sampled on the leading edge of its clock pulse. When bit 6 is 1, each bit is driven on the leading edge and sampled on the trailing edge.
- R5: Each half period of `sclk` lasts (prescaler/2)·(1 + SCR) core cycles, where SCR is control 0 bits 15:8.
- R6: Status (word 0x0C) holds these bits: bit 0 TX FIFO empty, bit 1 TX FIFO not full, bit 2 RX FIFO not empty, bit 3 RX FIFO full, bit 4 busy. Busy means a frame is shifting or the TX FIFO holds data.
- R7: The TX FIFO holds 8 frames and sends them in order. A data write while it is full is dropped.
- R8: A read of the data word pops the oldest received frame. A read while the RX FIFO is empty returns 0.
- R9: If a frame completes while the RX FIFO is full, that frame is discarded and interrupt status bit 2 sets. The bit stays set until any write to word 0x14.
- R10: Interrupt status (word 0x14) reports bit 0 when the RX FIFO is not empty and control 1 bit 0 is set. It reports bit 1 when the TX FIFO holds at most 4 frames and control 1 bit 1 is set. It reports bit 2 when an overrun is pending and control 1 bit 2 is set. `irq` is the OR of these three bits.
- R11: When control 1 bit 3 is set, the receiver takes `mosi` and ignores `miso`. When bit 3 is clear, the receiver takes `miso`.
- R12: While control 1 bit 4 is 0, `sclk` holds its idle level, no frame starts, and FIFO contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (5) | Byte address; bits 1:0 must be zero |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the strobe cycle |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Combined masked interrupt |

## Verification
The assertions assume three things about the inputs. First, software changes control 0 and the prescaler only while the port is disabled or idle. Second, the frame-size field is never below 3. Third, each access strobe lasts one cycle. The stimulus reconfigures a frame only after it clears the enable bit, and it uses only legal frame sizes. It issues each bus access as a single-cycle pulse that is set up and removed on falling clock edges. The overrun and FIFO-full cases are reached through legal bursts of data writes with no reads in between.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  // word indices of the register map (byte address bits 4:2)
  localparam logic [2:0] RG_CTRL0 = 3'd0;
  localparam logic [2:0] RG_CTRL1 = 3'd1;
  localparam logic [2:0] RG_DATA  = 3'd2;
  localparam logic [2:0] RG_STAT  = 3'd3;
  localparam logic [2:0] RG_PRE   = 3'd4;
  localparam logic [2:0] RG_INT   = 3'd5;

  // control 1 bit positions
  localparam int C1_RXIE = 0;
  localparam int C1_TXIE = 1;
  localparam int C1_OVIE = 2;
  localparam int C1_LOOP = 3;
  localparam int C1_EN   = 4;

  // core cycles per serial clock half period
  function automatic logic [15:0] half_period(input logic [6:0] pre_half,
                                              input logic [7:0] scr);
    return 16'(pre_half) * (16'(scr) + 16'd1);
  endfunction

  // ones over the active frame bits, size field = bits - 1
  function automatic logic [15:0] frame_mask(input logic [3:0] dss);
    return 16'hFFFF >> (4'd15 - dss);
  endfunction

  // prescaler halves stored from a written byte; even values, minimum 2
  function automatic logic [6:0] pre_norm(input logic [6:0] upper);
    return (upper == 7'd0) ? 7'd1 : upper;
  endfunction
endpackage

// File: rtl/ssp_fifo.sv
module ssp_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DW-1:0]     din,
  input  logic              pop,
  output logic [DW-1:0]     dout,
  output logic [$clog2(DEPTH):0] count,
  output logic              full,
  output logic              empty
);
  localparam int PW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;

  wire do_push = push && !full;
  wire do_pop  = pop && !empty;

  assign full  = (count == (PW+1)'(DEPTH));
  assign empty = (count == '0);
  assign dout  = empty ? '0 : mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) begin
        mem[wptr] <= din;
        wptr      <= wptr + 1'b1;
      end
      if (do_pop) rptr <= rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cpol,
  input  logic          cpha,
  input  logic [3:0]    dss,
  input  logic [15:0]   half_len,
  input  logic          has_data,
  input  logic [DW-1:0] tx_word,
  input  logic          rx_in,
  output logic          tx_pop,
  output logic          active,
  output logic          sclk,
  output logic          mosi,
  output logic          frame_done,
  output logic [DW-1:0] rx_word
);
  logic [15:0]   hcnt;
  logic          lead_next;
  logic [3:0]    bitidx;
  logic [DW-1:0] tx_q, rx_q;

  wire           tick   = active && (hcnt == half_len - 16'd1);
  wire [DW-1:0]  rx_nxt = {rx_q[DW-2:0], rx_in};

  assign tx_pop     = en && !active && has_data;
  assign frame_done = tick && !lead_next && (bitidx == 4'd0);
  assign rx_word    = cpha ? rx_nxt : rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      sclk      <= 1'b0;
      mosi      <= 1'b0;
      hcnt      <= '0;
      lead_next <= 1'b1;
      bitidx    <= '0;
      tx_q      <= '0;
      rx_q      <= '0;
    end else if (!en) begin
      active <= 1'b0;
      sclk   <= cpol;
    end else if (tx_pop) begin
      active    <= 1'b1;
      tx_q      <= tx_word;
      bitidx    <= dss;
      hcnt      <= '0;
      lead_next <= 1'b1;
      rx_q      <= '0;
      sclk      <= cpol;
      if (!cpha) mosi <= tx_word[dss];
    end else if (active) begin
      if (tick) begin
        hcnt <= '0;
        sclk <= ~sclk;
        if (lead_next) begin
          lead_next <= 1'b0;
          if (!cpha) rx_q <= rx_nxt;
          else       mosi <= tx_q[bitidx];
        end else begin
          lead_next <= 1'b1;
          if (cpha) rx_q <= rx_nxt;
          if (bitidx == 4'd0) begin
            active <= 1'b0;
          end else begin
            bitidx <= bitidx - 4'd1;
            if (!cpha) mosi <= tx_q[bitidx - 4'd1];
          end
        end
      end else begin
        hcnt <= hcnt + 16'd1;
      end
    end else begin
      sclk <= cpol;
    end
  end
endmodule

// File: rtl/ssp_master.sv
module ssp_master
  import ssp_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso,
  output logic          irq
);
  localparam int DW = 16;
  localparam int CW = $clog2(DEPTH) + 1;

  logic [15:0] cr0_q;
  logic [6:0]  cr1_q;
  logic [6:0]  pre_q;
  logic        ror_flag;

  // bus decode
  wire         hit    = bus_sel && (bus_addr[1:0] == 2'b00) && ((bus_addr >> 5) == '0);
  wire [2:0]   idx    = bus_addr[4:2];
  wire         wr_hit = hit && bus_wr;
  wire         rd_hit = hit && !bus_wr;

  // configuration views
  wire         port_en  = cr1_q[C1_EN];
  wire         loop_en  = cr1_q[C1_LOOP];
  wire         cpol     = cr0_q[7];
  wire         cpha     = cr0_q[6];
  wire [3:0]   dss      = cr0_q[3:0];
  wire [15:0]  half_len = half_period(pre_q, cr0_q[15:8]);

  // internal events, named for the checker
  logic          tx_pop, active, frame_done, mosi_int;
  logic [DW-1:0] tx_dout, rx_dout, rx_word;
  logic [CW-1:0] tx_count, rx_count;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  wire           tx_push = wr_hit && (idx == RG_DATA);
  wire           rx_pop  = rd_hit && (idx == RG_DATA);
  wire           rx_push = frame_done && !rx_full;
  wire           ror_set = frame_done && rx_full;
  wire           ror_clr = wr_hit && (idx == RG_INT);
  wire           busy    = active || !tx_empty;
  wire           tx_low  = (tx_count <= CW'(DEPTH / 2));
  wire           rx_in   = loop_en ? mosi_int : miso;
  wire [2:0]     int_st  = {ror_flag & cr1_q[C1_OVIE],
                            tx_low   & cr1_q[C1_TXIE],
                            !rx_empty & cr1_q[C1_RXIE]};

  ssp_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txf (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .din(bus_wdata & frame_mask(dss)),
    .pop(tx_pop), .dout(tx_dout), .count(tx_count), .full(tx_full), .empty(tx_empty));

  ssp_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxf (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_word),
    .pop(rx_pop), .dout(rx_dout), .count(rx_count), .full(rx_full), .empty(rx_empty));

  ssp_shifter #(.DW(DW)) u_shf (
    .clk(clk), .rst_n(rst_n), .en(port_en), .cpol(cpol), .cpha(cpha), .dss(dss),
    .half_len(half_len), .has_data(!tx_empty), .tx_word(tx_dout), .rx_in(rx_in),
    .tx_pop(tx_pop), .active(active), .sclk(sclk), .mosi(mosi_int),
    .frame_done(frame_done), .rx_word(rx_word));

  assign mosi = mosi_int;
  assign irq  = |int_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr0_q    <= '0;
      cr1_q    <= '0;
      pre_q    <= 7'd1;
      ror_flag <= 1'b0;
    end else begin
      if (wr_hit && idx == RG_CTRL0) cr0_q <= bus_wdata;
      if (wr_hit && idx == RG_CTRL1) cr1_q <= bus_wdata[6:0];
      if (wr_hit && idx == RG_PRE)   pre_q <= pre_norm(bus_wdata[7:1]);
      if (ror_set)      ror_flag <= 1'b1;
      else if (ror_clr) ror_flag <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_hit) begin
      case (idx)
        RG_CTRL0: bus_rdata = cr0_q;
        RG_CTRL1: bus_rdata = {9'd0, cr1_q};
        RG_DATA:  bus_rdata = rx_dout;
        RG_STAT:  bus_rdata = {11'd0, busy, rx_full, !rx_empty, !tx_full, tx_empty};
        RG_PRE:   bus_rdata = {8'd0, pre_q, 1'b0};
        RG_INT:   bus_rdata = {13'd0, int_st};
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ssp_master_chk.sv
module ssp_master_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          port_en,
  input logic          cpol,
  input logic          sclk,
  input logic          active,
  input logic          busy,
  input logic          frame_done,
  input logic          rx_full,
  input logic          rx_pop,
  input logic          ror_flag,
  input logic          ror_clr,
  input logic          irq,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_count
);
  // R12: a disabled port parks the clock at the idle level
  p_idle_sclk_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (sclk == $past(cpol)));

  // R9: a frame completing into a full RX FIFO raises the overrun flag
  p_ovr_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rx_full) |=> ror_flag);

  // R9: the overrun flag holds until the clear write
  p_ovr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ror_flag && !ror_clr) |=> ror_flag);

  // R9: the discarded frame does not enter the RX FIFO
  p_ovr_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rx_full && !rx_pop) |=> (rx_count == $past(rx_count)));

  // R7: TX occupancy never exceeds its depth
  p_tx_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= CW'(DEPTH));

  // R6: a shifting frame is always reported busy
  p_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> busy);

  // R10: the interrupt only rises for a real cause
  p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ror_flag || rx_count != '0 || tx_count <= CW'(DEPTH / 2)));
endmodule

bind ssp_master ssp_master_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .cpol(cpol), .sclk(sclk),
  .active(active), .busy(busy), .frame_done(frame_done), .rx_full(rx_full),
  .rx_pop(rx_pop), .ror_flag(ror_flag), .ror_clr(ror_clr), .irq(irq),
  .tx_count(tx_count), .rx_count(rx_count));

// File: tb/sim_ssp_master.sv
module sim_ssp_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        sclk, mosi, irq;
  logic        miso = 1'b0;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;   // 125 MHz

  ssp_master u0 (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .irq(irq));

  localparam int A_C0 = 'h00, A_C1 = 'h04, A_DR = 'h08, A_SR = 'h0C, A_PRE = 'h10, A_INT = 'h14;

  // {ctrl0, prescaler, data}
  localparam logic [39:0] VEC [8] = '{
    {16'h0007, 8'd2,   16'h00A5},
    {16'h00C7, 8'd4,   16'h003C},
    {16'h014F, 8'd2,   16'hBEEF},
    {16'h0283, 8'd6,   16'h0009},
    {16'h000B, 8'd2,   16'hF123},
    {16'h0046, 8'd9,   16'h00FF},
    {16'h038E, 8'd2,   16'h5555},
    {16'h00C9, 8'd254, 16'h02C6}
  };

  // serial line monitor
  logic mon_clr = 1'b0, mon_cpol = 1'b0, mon_cpha = 1'b0;
  int   mon_half = 1;
  int   cyc = 0, last_edge = 0, edges = 0, bad_iv = 0;
  logic [15:0] cap = '0;
  logic psclk = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (mon_clr) begin
      edges = 0; cap = '0; bad_iv = 0; last_edge = cyc;
    end else if (sclk !== psclk) begin
      if (edges != 0 && (cyc - last_edge) != mon_half) bad_iv++;
      last_edge = cyc;
      edges++;
      if ((sclk != mon_cpol) ^ mon_cpha) cap = {cap[14:0], mosi};
    end
    psclk = sclk;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a[4:0]; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a[4:0];
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int k = 0; k < 20000; k++) begin
      rd(A_SR, s);
      if (!s[4]) break;
    end
  endtask

  task automatic report();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    logic [15:0] v, msk;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 sclk", 32'(sclk), 0);
    chk("R1 irq", 32'(irq), 0);
    rd(A_SR, v);  chk("R1 status", 32'(v), 32'h3);
    rd(A_PRE, v); chk("R1 prescaler", 32'(v), 2);
    rd(A_C0, v);  chk("R1 ctrl0", 32'(v), 0);
    rd(A_C1, v);  chk("R1 ctrl1", 32'(v), 0);
    rd(A_INT, v); chk("R1 int", 32'(v), 0);

    // R2: register readback
    wr(A_C0, 16'h1234); rd(A_C0, v); chk("R2 ctrl0", 32'(v), 32'h1234);
    wr(A_C1, 16'hFFFF); rd(A_C1, v); chk("R2 ctrl1", 32'(v), 32'h7F);
    wr(A_C1, 16'h0000);
    wr(A_PRE, 16'h0009); rd(A_PRE, v); chk("R2 pre odd", 32'(v), 8);
    wr(A_PRE, 16'h0001); rd(A_PRE, v); chk("R2 pre min", 32'(v), 2);

    // R8: empty read returns zero
    rd(A_DR, v); chk("R8 empty read", 32'(v), 0);

    // R3 R4 R5: table of frames in loopback
    for (int i = 0; i < 8; i++) begin
      logic [15:0] c0, dat;
      logic [7:0]  pre;
      int size, half;
      {c0, pre, dat} = VEC[i];
      size = int'(c0[3:0]) + 1;
      half = ((pre < 2) ? 1 : int'(pre) / 2) * (int'(c0[15:8]) + 1);
      msk  = 16'((32'd1 << size) - 1);
      wr(A_C1, 16'h0000);
      wr(A_C0, c0);
      wr(A_PRE, {8'd0, pre});
      @(posedge clk);
      mon_cpol = c0[7]; mon_cpha = c0[6]; mon_half = half; mon_clr = 1'b1;
      @(posedge clk);
      mon_clr = 1'b0;
      chk($sformatf("R4 idle level vec %0d", i), 32'(sclk), 32'(c0[7]));
      wr(A_C1, 16'h0018);
      wr(A_DR, dat);
      wait_idle();
      rd(A_DR, v);
      chk($sformatf("R3 rx vec %0d", i), 32'(v), 32'(dat & msk));
      chk($sformatf("R4 mosi order vec %0d", i), 32'(cap & msk), 32'(dat & msk));
      chk($sformatf("R5 edge count vec %0d", i), edges, 2 * size);
      chk($sformatf("R5 half period vec %0d", i), bad_iv, 0);
      chk($sformatf("R4 back to idle vec %0d", i), 32'(sclk), 32'(c0[7]));
    end

    // R11: external input versus loopback
    wr(A_C1, 16'h0000); wr(A_C0, 16'h0007); wr(A_PRE, 16'h0002);
    wr(A_C1, 16'h0010);
    miso = 1'b1; wr(A_DR, 16'h0000); wait_idle(); rd(A_DR, v);
    chk("R11 miso high", 32'(v), 32'hFF);
    miso = 1'b0; wr(A_DR, 16'h00FF); wait_idle(); rd(A_DR, v);
    chk("R11 miso low", 32'(v), 32'h00);
    wr(A_C1, 16'h0018);
    miso = 1'b1; wr(A_DR, 16'h005A); wait_idle(); rd(A_DR, v);
    chk("R11 loopback ignores miso", 32'(v), 32'h5A);
    miso = 1'b0;

    // R9: overrun, 4-bit frames, overrun interrupt enabled
    wr(A_C1, 16'h0000); wr(A_C0, 16'h0003);
    wr(A_C1, 16'h001C);
    for (int i = 1; i <= 9; i++) wr(A_DR, 16'(i));
    wait_idle();
    rd(A_SR, v);  chk("R6 status rx full", 32'(v), 32'h0F);
    rd(A_INT, v); chk("R9 overrun flag", 32'(v), 32'h4);
    chk("R10 irq on overrun", 32'(irq), 1);
    repeat (20) @(negedge clk);
    rd(A_INT, v); chk("R9 overrun sticky", 32'(v), 32'h4);
    wr(A_INT, 16'h0000);
    rd(A_INT, v); chk("R9 overrun cleared", 32'(v), 0);
    chk("R10 irq cleared", 32'(irq), 0);
    for (int i = 1; i <= 8; i++) begin
      rd(A_DR, v); chk($sformatf("R9 kept frame %0d", i), 32'(v), i);
    end
    rd(A_SR, v); chk("R9 ninth discarded", 32'(v), 32'h3);

    // R12 R7: disabled port holds data; full TX drops writes
    wr(A_C1, 16'h0000); wr(A_C0, 16'h0083);
    for (int i = 1; i <= 10; i++) wr(A_DR, 16'(i));
    rd(A_SR, v); chk("R7 tx full status", 32'(v), 32'h10);
    repeat (50) @(negedge clk);
    chk("R12 sclk idle while disabled", 32'(sclk), 1);
    rd(A_SR, v); chk("R12 fifo kept", 32'(v), 32'h10);
    wr(A_C1, 16'h0018);
    wait_idle();
    for (int i = 1; i <= 8; i++) begin
      rd(A_DR, v); chk($sformatf("R7 order frame %0d", i), 32'(v), i);
    end
    rd(A_SR, v); chk("R7 extra writes dropped", 32'(v), 32'h3);

    // R10: transmit threshold and receive pending
    wr(A_C1, 16'h0002);
    rd(A_INT, v); chk("R10 tx low empty", 32'(v), 32'h2);
    for (int i = 0; i < 4; i++) wr(A_DR, 16'h0005);
    rd(A_INT, v); chk("R10 tx low at four", 32'(v), 32'h2);
    chk("R10 irq tx low", 32'(irq), 1);
    wr(A_DR, 16'h0005);
    rd(A_INT, v); chk("R10 tx above four", 32'(v), 0);
    chk("R10 irq low", 32'(irq), 0);
    wr(A_C1, 16'h0019);
    wait_idle();
    rd(A_INT, v); chk("R10 rx pending", 32'(v), 32'h1);
    for (int i = 0; i < 5; i++) begin
      rd(A_DR, v); chk("R3 4-bit drain", 32'(v), 5);
    end
    rd(A_INT, v); chk("R10 rx drained", 32'(v), 0);

    report();
    $finish;
  end
endmodule